// File: doc/BRIEF.md
# DDR SRAM Command Scheduler

This block is the controller between a host that issues whole 36-bit memory requests and one or more burst-of-two, double-data-rate synchronous SRAM banks. The host presents a request with a valid/ready handshake: a read or write flag, a word address, 36 bits of write data and four byte enables. Each accepted request becomes one command on the memory pins in the following cycle. The command is one active-low load strobe per bank, a shared read/write select and a shared address. A write's data goes out in the cycle after its command as two 18-bit beats, each with its own active-low 9-bit lane selects.

The controller keeps the data bus clean when the direction turns. A write may not start until three idle cycles have passed after the last read. Reads may follow reads, writes may follow writes, and a read may follow a write, all on consecutive cycles. During a turnaround the host is stalled by dropping ready. On the read side, the SRAM raises a valid-data indicator one cycle before it presents the two beats. The controller uses that indicator to capture both beats and returns them as a single 36-bit response. It counts the reads still in flight and stalls further reads when the limit is reached, so responses always come back in request order.

The bank is picked from the top address bits. Only that bank's load strobe falls, and every other pin is shared by all banks.

Top module: `ddr_sram_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bank load strobe is high, the read/write select is high, all lane selects are high, the write beats are zero and `rsp_valid` is low.
- R2: A request accepted at a clock edge drives its command during the next cycle. The load strobe of bank `req_addr[AW-1 -: log2(NBANK)]` is low, `mem_rw` is 1 for a read and 0 for a write, and `mem_addr` equals `req_addr[AW-log2(NBANK)-1:0]`.
- R3: In every cycle that does not follow an accepted request, all load strobes are high, which makes it a no-operation cycle. In no cycle is more than one load strobe low.
- R4: In the cycle after a write command, `mem_d_rise` carries `req_wdata[17:0]` and `mem_d_fall` carries `req_wdata[35:18]` of that write.
- R5: In that same cycle, `mem_bws_rise_n[i]` is `!req_be[i]` and `mem_bws_fall_n[i]` is `!req_be[2+i]`. Lane i of a beat is bits 9i+8:9i of that beat. In every other cycle all four lane selects are high.
- R6: After a read is accepted, a write request is refused (ready low) for exactly RW_GAP = 3 cycles, so exactly three no-operation cycles separate the read command from the write command.
- R7: Back-to-back reads and back-to-back writes are accepted on every consecutive cycle with no stall, provided the read limit of R10 is not reached.
- R8: A read requested right after a write is accepted with no idle cycle. A read of a just-written address returns the write's data merged lane by lane into the earlier content.
- R9: When `mem_qvld` is high in cycle t, the beats on `mem_q_rise` and `mem_q_fall` in cycle t+1 are returned in cycle t+2 with `rsp_valid` high and `rsp_data = {mem_q_fall, mem_q_rise}`. Responses return in request order.
- R10: While MAX_RD = 4 reads are outstanding (accepted, with no response yet returned), a read request is refused with ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands, beats and captures on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address; top bits pick the bank |
| req_wdata | input | 36 | Write word; low half is the first beat |
| req_be | input | 4 | Byte enables, one per 9-bit lane |
| rsp_valid | output | 1 | Read response present for one cycle |
| rsp_data | output | 36 | Read word; low half is the first beat |
| mem_ld_n | output | NBANK | Active-low load strobe, one per bank |
| mem_rw | output | 1 | 1 = read, 0 = write (shared) |
| mem_addr | output | AW-log2(NBANK) | Shared bank-local address |
| mem_d_rise | output | 18 | First write beat |
| mem_d_fall | output | 18 | Second write beat |
| mem_bws_rise_n | output | 2 | Active-low lane selects of the first beat |
| mem_bws_fall_n | output | 2 | Active-low lane selects of the second beat |
| mem_q_rise | input | 18 | First read beat from the SRAM |
| mem_q_fall | input | 18 | Second read beat from the SRAM |
| mem_qvld | input | 1 | Read data indicator, one cycle ahead of the beats |

## Verification
The hardest state to reach from the ports is the read limit. With a short memory latency the in-flight count never rises above three. The bench's SRAM model therefore has a latency that can be set: a long stream of reads is run with it lengthened so that the count hits four and ready drops. The exact three-cycle read-to-write turnaround is reached by holding a write request valid right behind a read and counting the refused cycles. A write followed at once by a read of the same address, with two of the four lanes enabled, exercises merging into earlier data.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int BEAT_W = 18;
  localparam int LANE_W = 9;
  localparam int LANES  = BEAT_W / LANE_W;
  localparam int BEATS  = 2;
  localparam int WORD_W = BEAT_W * BEATS;
  localparam int BE_W   = LANES * BEATS;

  typedef logic [BEAT_W-1:0] beat_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } cmd_e;

  // beat idx of a host word (0 = first beat)
  function automatic beat_t beat_of(input word_t w, input int idx);
    return w[idx*BEAT_W +: BEAT_W];
  endfunction

  // active-low lane selects for beat idx from host byte enables
  function automatic logic [LANES-1:0] lane_sel_n(input logic [BE_W-1:0] be, input int idx);
    return ~be[idx*LANES +: LANES];
  endfunction

  function automatic word_t join_beats(input beat_t first, input beat_t second);
    return {second, first};
  endfunction

endpackage

// File: rtl/sched_turnaround.sv
module sched_turnaround #(
  parameter int RW_GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_acc,
  output logic wr_block
);
  localparam int GW = $clog2(RW_GAP + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (rd_acc) begin
      gap_q <= GW'(RW_GAP);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign wr_block = (gap_q != '0);

endmodule

// File: rtl/sched_issue.sv
module sched_issue
  import sched_pkg::*;
#(
  parameter int AW    = 20,
  parameter int NBANK = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  word_t                      wdata,
  input  logic [BE_W-1:0]            be,
  output logic [NBANK-1:0]           ld_n,
  output logic                       rw,
  output logic [AW-$clog2(NBANK)-1:0] maddr,
  output beat_t                      d_rise,
  output beat_t                      d_fall,
  output logic [LANES-1:0]           sel_rise_n,
  output logic [LANES-1:0]           sel_fall_n,
  output logic                       cmd_rd,
  output logic                       cmd_wr
);
  localparam int BB  = $clog2(NBANK);
  localparam int MAW = AW - BB;

  cmd_e                   cmd_q;
  logic [BB-1:0]          bank_q;
  logic [MAW-1:0]         addr_q;
  word_t                  wbuf_q;
  logic [BE_W-1:0]        wbe_q;
  beat_t                  beat_q [BEATS];
  logic [LANES-1:0]       sel_q  [BEATS];

  // command stage: one edge after acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      wbuf_q <= '0;
      wbe_q  <= '0;
    end else begin
      cmd_q <= !acc ? CMD_NOP : (wr ? CMD_WR : CMD_RD);
      if (acc) begin
        bank_q <= addr[AW-1 -: BB];
        addr_q <= addr[MAW-1:0];
      end
      if (acc && wr) begin
        wbuf_q <= wdata;
        wbe_q  <= be;
      end
    end
  end

  // data stage: one edge after the write command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BEATS; b++) begin
        beat_q[b] <= '0;
        sel_q[b]  <= '1;
      end
    end else begin
      for (int b = 0; b < BEATS; b++) begin
        if (cmd_q == CMD_WR) begin
          beat_q[b] <= beat_of(wbuf_q, b);
          sel_q[b]  <= lane_sel_n(wbe_q, b);
        end else begin
          beat_q[b] <= '0;
          sel_q[b]  <= '1;
        end
      end
    end
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_bank_ld
    assign ld_n[k] = !((cmd_q != CMD_NOP) && (bank_q == BB'(k)));
  end

  assign rw         = (cmd_q != CMD_WR);
  assign maddr      = addr_q;
  assign d_rise     = beat_q[0];
  assign d_fall     = beat_q[1];
  assign sel_rise_n = sel_q[0];
  assign sel_fall_n = sel_q[1];
  assign cmd_rd     = (cmd_q == CMD_RD);
  assign cmd_wr     = (cmd_q == CMD_WR);

endmodule

// File: rtl/sched_rdpath.sv
module sched_rdpath
  import sched_pkg::*;
#(
  parameter int MAX_RD = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_acc,
  input  logic                          qvld,
  input  beat_t                         q_rise,
  input  beat_t                         q_fall,
  output logic                          rsp_valid,
  output word_t                         rsp_data,
  output logic                          rd_full,
  output logic [$clog2(MAX_RD+1)-1:0]   outstanding
);
  localparam int CW = $clog2(MAX_RD + 1);

  logic          cap_pend_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c,
                                             input logic inc, input logic dec);
    case ({inc, dec})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pend_q <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      cnt_q      <= '0;
    end else begin
      cap_pend_q <= qvld;
      rsp_valid  <= cap_pend_q;
      if (cap_pend_q) begin
        rsp_data <= join_beats(q_rise, q_fall);
      end
      cnt_q <= next_cnt(cnt_q, rd_acc, cap_pend_q);
    end
  end

  assign rd_full     = (cnt_q == CW'(MAX_RD));
  assign outstanding = cnt_q;

endmodule

// File: rtl/ddr_sram_sched.sv
module ddr_sram_sched #(
  parameter int AW     = 20,
  parameter int NBANK  = 2,
  parameter int MAX_RD = 4,
  parameter int RW_GAP = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [AW-1:0]               req_addr,
  input  logic [35:0]                 req_wdata,
  input  logic [3:0]                  req_be,
  output logic                        rsp_valid,
  output logic [35:0]                 rsp_data,
  output logic [NBANK-1:0]            mem_ld_n,
  output logic                        mem_rw,
  output logic [AW-$clog2(NBANK)-1:0] mem_addr,
  output logic [17:0]                 mem_d_rise,
  output logic [17:0]                 mem_d_fall,
  output logic [1:0]                  mem_bws_rise_n,
  output logic [1:0]                  mem_bws_fall_n,
  input  logic [17:0]                 mem_q_rise,
  input  logic [17:0]                 mem_q_fall,
  input  logic                        mem_qvld
);
  localparam int CW = $clog2(MAX_RD + 1);

  // named internal events for the checker
  logic          wr_block;
  logic          rd_full;
  logic          acc;
  logic          rd_acc;
  logic          cmd_rd;
  logic          cmd_wr;
  logic [CW-1:0] rd_outstanding;

  assign req_ready = req_write ? !wr_block : !rd_full;
  assign acc       = req_valid && req_ready;
  assign rd_acc    = acc && !req_write;

  sched_turnaround #(.RW_GAP(RW_GAP)) u_turn (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_acc   (rd_acc),
    .wr_block (wr_block)
  );

  sched_issue #(.AW(AW), .NBANK(NBANK)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .wr         (req_write),
    .addr       (req_addr),
    .wdata      (req_wdata),
    .be         (req_be),
    .ld_n       (mem_ld_n),
    .rw         (mem_rw),
    .maddr      (mem_addr),
    .d_rise     (mem_d_rise),
    .d_fall     (mem_d_fall),
    .sel_rise_n (mem_bws_rise_n),
    .sel_fall_n (mem_bws_fall_n),
    .cmd_rd     (cmd_rd),
    .cmd_wr     (cmd_wr)
  );

  sched_rdpath #(.MAX_RD(MAX_RD)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_acc      (rd_acc),
    .qvld        (mem_qvld),
    .q_rise      (mem_q_rise),
    .q_fall      (mem_q_fall),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rd_full     (rd_full),
    .outstanding (rd_outstanding)
  );

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int NBANK  = 2,
  parameter int MAX_RD = 4,
  parameter int RW_GAP = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [NBANK-1:0]              mem_ld_n,
  input logic [1:0]                    mem_bws_rise_n,
  input logic [1:0]                    mem_bws_fall_n,
  input logic                          mem_qvld,
  input logic                          rsp_valid,
  input logic                          cmd_rd,
  input logic                          cmd_wr,
  input logic [$clog2(MAX_RD+1)-1:0]   rd_outstanding
);
  localparam int SW = $clog2(RW_GAP + 1);

  // cycles since the last read command on the pins, saturating
  logic [SW-1:0] since_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_rd <= SW'(RW_GAP);
    else if (cmd_rd)                since_rd <= '0;
    else if (since_rd != SW'(RW_GAP)) since_rd <= since_rd + 1'b1;
  end

  assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_rd || cmd_wr));

  assert_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (&mem_ld_n));

  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ld_n));

  assert_lanes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (mem_bws_rise_n == 2'b11 && mem_bws_fall_n == 2'b11));

  assert_rd_wr_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (since_rd >= SW'(RW_GAP)));

  assert_rsp_follows_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_qvld, 2));

  assert_rd_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_outstanding <= ($clog2(MAX_RD+1))'(MAX_RD));

endmodule

bind ddr_sram_sched sched_checker #(
  .NBANK (NBANK),
  .MAX_RD(MAX_RD),
  .RW_GAP(RW_GAP)
) u_sched_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .mem_ld_n       (mem_ld_n),
  .mem_bws_rise_n (mem_bws_rise_n),
  .mem_bws_fall_n (mem_bws_fall_n),
  .mem_qvld       (mem_qvld),
  .rsp_valid      (rsp_valid),
  .cmd_rd         (cmd_rd),
  .cmd_wr         (cmd_wr),
  .rd_outstanding (rd_outstanding)
);

// File: tb/ddr_sram_sched_bench.sv
module ddr_sram_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW     = 20;
  localparam int NBANK  = 2;
  localparam int MAX_RD = 4;
  localparam int RW_GAP = 3;
  localparam int BB     = 1;
  localparam int MAW    = AW - BB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [35:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic rsp_valid;
  logic [35:0] rsp_data;
  logic [NBANK-1:0] mem_ld_n;
  logic mem_rw;
  logic [MAW-1:0] mem_addr;
  logic [17:0] mem_d_rise, mem_d_fall;
  logic [1:0] mem_bws_rise_n, mem_bws_fall_n;
  logic [17:0] mem_q_rise = '0, mem_q_fall = '0;
  logic mem_qvld = 1'b0;

  ddr_sram_sched #(.AW(AW), .NBANK(NBANK), .MAX_RD(MAX_RD), .RW_GAP(RW_GAP)) u_ddr_sram_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_ld_n(mem_ld_n), .mem_rw(mem_rw),
    .mem_addr(mem_addr), .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
    .mem_bws_rise_n(mem_bws_rise_n), .mem_bws_fall_n(mem_bws_fall_n),
    .mem_q_rise(mem_q_rise), .mem_q_fall(mem_q_fall), .mem_qvld(mem_qvld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, iter = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, iter);
    end
  endtask

  // reference state
  bit p_acc = 0, p_wr = 0, pp_wr = 0;
  logic [AW-1:0] p_addr = '0;
  logic [35:0] p_data = '0, pp_data = '0;
  logic [3:0]  p_be = '0, pp_be = '0;
  int last_rd = -100, rd_total = 0, rsp_total = 0, sram_lat = 1;
  logic [35:0] hmem [int];
  logic [35:0] smem [int];
  logic [35:0] exp_q [$];
  bit vld_at [int];
  int q_at [int];
  bit s_wr_pend = 0;
  int s_wr_key = 0;

  function automatic logic [35:0] lane_merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] en);
    logic [35:0] r = old;
    for (int j = 0; j < 4; j++) if (en[j]) r[j*9 +: 9] = nw[j*9 +: 9];
    return r;
  endfunction

  task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                      input logic [35:0] d, input logic [3:0] be, output bit acc);
    logic [NBANK-1:0] exp_ld;
    logic [35:0] e, val;
    bit exp_rdy;
    int bank, key;
    @(negedge clk);
    iter++;
    // command pins (R2, R3)
    exp_ld = p_acc ? ~(NBANK'(1) << p_addr[AW-1 -: BB]) : '1;
    chk(mem_ld_n == exp_ld, p_acc ? "R2 load strobe" : "R3 nop strobe", 64'(mem_ld_n), 64'(exp_ld));
    if (p_acc) begin
      chk(mem_rw == !p_wr, "R2 rw", 64'(mem_rw), 64'(!p_wr));
      chk(mem_addr == p_addr[MAW-1:0], "R2 addr", 64'(mem_addr), 64'(p_addr[MAW-1:0]));
    end
    // write beats (R4, R5)
    if (pp_wr) begin
      chk(mem_d_rise == pp_data[17:0], "R4 first beat", 64'(mem_d_rise), 64'(pp_data[17:0]));
      chk(mem_d_fall == pp_data[35:18], "R4 second beat", 64'(mem_d_fall), 64'(pp_data[35:18]));
      chk({mem_bws_fall_n, mem_bws_rise_n} == ~pp_be, "R5 lane selects",
          64'({mem_bws_fall_n, mem_bws_rise_n}), 64'(~pp_be));
    end else begin
      chk({mem_bws_fall_n, mem_bws_rise_n} == 4'hf, "R5 lanes idle",
          64'({mem_bws_fall_n, mem_bws_rise_n}), 64'hf);
    end
    // SRAM model from the pins
    if (s_wr_pend) begin
      val = smem.exists(s_wr_key) ? smem[s_wr_key] : '0;
      smem[s_wr_key] = lane_merge(val, {mem_d_fall, mem_d_rise}, ~{mem_bws_fall_n, mem_bws_rise_n});
    end
    s_wr_pend = 0;
    if (mem_ld_n != '1) begin
      bank = 0;
      for (int k = 0; k < NBANK; k++) if (!mem_ld_n[k]) bank = k;
      key = (bank << MAW) | int'(mem_addr);
      if (!mem_rw) begin
        s_wr_pend = 1; s_wr_key = key;
      end else begin
        vld_at[iter + sram_lat] = 1;
        q_at[iter + sram_lat + 1] = key;
      end
    end
    // responses (R9)
    if (rsp_valid) begin
      rsp_total++;
      if (exp_q.size() == 0) chk(0, "R9 unexpected response", 64'(rsp_data), 64'h0);
      else begin
        e = exp_q.pop_front();
        chk(rsp_data == e, "R9 response data", 64'(rsp_data), 64'(e));
      end
    end
    mem_qvld = vld_at.exists(iter);
    if (q_at.exists(iter)) begin
      val = smem.exists(q_at[iter]) ? smem[q_at[iter]] : '0;
      mem_q_rise = val[17:0];
      mem_q_fall = val[35:18];
    end else begin
      mem_q_rise = '0;
      mem_q_fall = '0;
    end
    // host request
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    #1;
    if (v) begin
      exp_rdy = w ? ((iter - last_rd) > RW_GAP) : ((rd_total - rsp_total) < MAX_RD);
      chk(req_ready == exp_rdy, w ? "R6 write ready" : "R10 read ready", 64'(req_ready), 64'(exp_rdy));
    end
    acc = v && req_ready;
    if (acc) begin
      if (w) hmem[int'(a)] = lane_merge(hmem.exists(int'(a)) ? hmem[int'(a)] : '0, d, be);
      else begin
        exp_q.push_back(hmem.exists(int'(a)) ? hmem[int'(a)] : '0);
        rd_total++;
        last_rd = iter;
      end
    end
    pp_wr = p_acc && p_wr; pp_data = p_data; pp_be = p_be;
    p_acc = acc; p_wr = w; p_addr = a; p_data = d; p_be = be;
  endtask

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [35:0] d,
                       input logic [3:0] be, output int stalls);
    bit acc;
    stalls = 0;
    do begin
      step(1'b1, w, a, d, be, acc);
      if (!acc) stalls++;
    end while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, acc);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", iter);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st, tot;
    logic [AW-1:0] addrs [6];
    addrs = '{20'h00010, 20'h80010, 20'h00123, 20'h8ABCD, 20'h7FFFF, 20'hFFFFF};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ld_n == '1, "R1 strobes", 64'(mem_ld_n), 64'h3);
    chk(mem_rw == 1'b1, "R1 rw", 64'(mem_rw), 64'h1);
    chk({mem_bws_fall_n, mem_bws_rise_n} == 4'hf, "R1 lanes", 64'({mem_bws_fall_n, mem_bws_rise_n}), 64'hf);
    chk({mem_d_fall, mem_d_rise} == '0, "R1 beats", 64'({mem_d_fall, mem_d_rise}), 64'h0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'h0);
    rst_n = 1'b1;
    idle(2);

    // R7 back-to-back writes over both banks
    tot = 0;
    for (int i = 0; i < 6; i++) begin
      issue(1'b1, addrs[i], {4'(i), 32'hA5C3_0F00 + 32'(i * 32'h1111_0101)}, 4'hF, st);
      tot += st;
    end
    chk(tot == 0, "R7 write stalls", 64'(tot), 64'h0);
    idle(3);

    // R7 back-to-back reads, R9 in-order data
    tot = 0;
    for (int i = 0; i < 6; i++) begin
      issue(1'b0, addrs[i], '0, 4'h0, st);
      tot += st;
    end
    chk(tot == 0, "R7 read stalls", 64'(tot), 64'h0);
    idle(10);

    // R6 read then write: exactly RW_GAP refused cycles
    issue(1'b0, addrs[2], '0, 4'h0, st);
    issue(1'b1, addrs[3], 36'h1_2345_6789, 4'hF, st);
    chk(st == RW_GAP, "R6 turnaround cycles", 64'(st), 64'(RW_GAP));
    idle(8);

    // R8 write then read same address, partial lanes (R5)
    issue(1'b1, addrs[0], 36'hF_FFFF_FFFF, 4'b0101, st);
    issue(1'b0, addrs[0], '0, 4'h0, st);
    chk(st == 0, "R8 write-to-read stalls", 64'(st), 64'h0);
    issue(1'b1, addrs[1], 36'h9_8765_4321, 4'b1010, st);
    issue(1'b0, addrs[1], '0, 4'h0, st);
    chk(st == 0, "R8 write-to-read stalls", 64'(st), 64'h0);
    idle(8);

    // R10 long latency makes the read limit bind
    sram_lat = 6;
    tot = 0;
    for (int i = 0; i < 10; i++) begin
      issue(1'b0, addrs[i % 6], '0, 4'h0, st);
      tot += st;
    end
    chk(tot > 0, "R10 read limit stalled", 64'(tot), 64'h1);
    idle(20);
    chk(exp_q.size() == 0, "R9 all responses returned", 64'(exp_q.size()), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule